// File: doc/BRIEF.md
# Serial EEPROM Address Decoder

This block sits behind the bit engine of a two-wire serial memory client. The engine hands it whole received bytes together with strobes for a start (or repeated start), a stop and a host not-acknowledge. The block judges the first byte after a start as a device address byte. It checks the type code and the 3-bit client address, and it records the read/write bit and whether the access targets the main array or the auxiliary register space. It then returns an acknowledge decision for that byte.

After a write-mode device address, the next byte is a word address. The block decodes it into one of these regions, each with a byte offset: the main array, the security register, the security lock function, the write-protect register, or an invalid register-space pattern. Register-space device addresses are refused while an earlier main-array transaction is still open, meaning it has not been closed by a stop or a host NACK.

The controller has five states. `ST_IDLE` waits for a start. `ST_DEV` expects a device address byte. `ST_WORD` expects a word address byte. `ST_DATA` lets payload bytes pass unjudged. `ST_IGNORE` stays silent after a refused device address or a host NACK. The transitions are:
- A start moves any state to `ST_DEV`.
- A stop moves any state to `ST_IDLE`.
- A host NACK moves any state other than `ST_IDLE` to `ST_IGNORE`.
- From `ST_DEV`, an acknowledged write byte goes to `ST_WORD`, an acknowledged read byte goes to `ST_DATA`, and a refused byte goes to `ST_IGNORE`.
- From `ST_WORD`, any byte goes to `ST_DATA`.

Top module: `eeprom_addr_decode`

## Requirements
- R1: A device address byte is acknowledged only if bits 7:4 equal 4'b1010 (main array, `reg_space`=0) or 4'b1011 (register space, `reg_space`=1). Any other type code gives `resp_ack`=0.
- R2: Bits 3:1 of a device address byte must equal `client_addr`. On a mismatch, `resp_ack`=0.
- R3: Bit 0 of an acknowledged device address byte is copied to `rd_flag` (1 = read, 0 = write). A write moves on to a word address byte. A read takes no word address, so `region` stays 0 (none).
- R4: `resp_valid` pulses for exactly one cycle, in the cycle after a judged byte is accepted, with the decision in `resp_ack`. Otherwise `resp_valid` is 0.
- R5: A main-array word address gives `region`=1. With ARRAY_ADDR_BITS=8, `offset` is the whole byte. With ARRAY_ADDR_BITS=7, bit 7 is ignored and `offset`={1'b0, byte[6:0]}.
- R6: In register space, word bits 7:6=2'b10 give `region`=2 (security) with `offset`={3'b000, byte[4:0]}, and bit 5 is ignored. A write-mode device address to register space is acknowledged.
- R7: In register space, word bits 7:4=4'b0110 give `region`=3 (lock function) with `offset`=0.
- R8: In register space, word bits 7:6=2'b11 give `region`=4 (write-protect) with `offset`=0.
- R9: Register-space word patterns not covered by R6–R8 give `region`=5 (invalid). Every word address byte is acknowledged.
- R10: A register-space device address is refused (`resp_ack`=0) if a main-array device address has been acknowledged since the last stop, host NACK or reset.
- R11: A start makes the next byte a device address byte and clears `region`, `offset`, `rd_flag` and `reg_space` to 0. After a stop or reset, bytes get no response until a start.
- R12: After a refused device address byte or a host NACK, bytes get no response until the next start.
- R13: Bytes after the word address (data phase) get no response and leave `region` and `offset` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| client_addr | input | 3 | Strapped client address |
| start_evt | input | 1 | Start or repeated start strobe |
| stop_evt | input | 1 | Stop condition strobe |
| host_nack | input | 1 | Host not-acknowledge strobe |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| resp_valid | output | 1 | Acknowledge decision valid |
| resp_ack | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| rd_flag | output | 1 | Read/write select of the accepted device address |
| reg_space | output | 1 | Accepted device address targets register space |
| region | output | 3 | Decoded target region code |
| offset | output | 8 | Byte offset within the region |

## Verification
The hardest situation to reach is the refusal in R10. It needs a main-array transaction that ends in a repeated start instead of a stop or NACK, followed straight away by a register-space device address. The directed part of the bench builds exactly that chain. It then repeats the chain after a host NACK and after a stop, to show that either one re-opens register access. In the random part, each transaction ends at random with a stop, a NACK or a bare repeated start. Type codes are biased toward the two legal codes, so open-transaction refusals and the re-opening of register access recur many times.

// File: rtl/ead_pkg.sv
package ead_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DEV    = 3'd1,
        ST_WORD   = 3'd2,
        ST_DATA   = 3'd3,
        ST_IGNORE = 3'd4
    } ead_state_t;

    typedef enum logic [2:0] {
        RGN_NONE    = 3'd0,
        RGN_ARRAY   = 3'd1,
        RGN_SECURE  = 3'd2,
        RGN_LOCK    = 3'd3,
        RGN_WPROT   = 3'd4,
        RGN_INVALID = 3'd5
    } ead_region_t;

    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_REGS  = 4'b1011;

endpackage

// File: rtl/ead_dev_match.sv
module ead_dev_match (
    input  logic [7:1] dev_bits,
    input  logic [2:0] client_addr,
    input  logic       clean_ok,
    output logic       is_regs,
    output logic       grant
);
    import ead_pkg::*;

    logic type_ok;
    logic addr_ok;

    always_comb begin
        // R1: only the two legal type codes are recognised
        type_ok = (dev_bits[7:4] == TYPE_ARRAY) || (dev_bits[7:4] == TYPE_REGS);
        is_regs = (dev_bits[7:4] == TYPE_REGS);
        // R2: strapped client address compare
        addr_ok = (dev_bits[3:1] == client_addr);
        // R10: register space only after clean close
        grant   = type_ok && addr_ok && (!is_regs || clean_ok);
    end
endmodule

// File: rtl/ead_word_decode.sv
module ead_word_decode #(
    parameter int ARRAY_ADDR_BITS = 8,
    parameter int SECURE_OFS_BITS = 5
) (
    input  logic [7:0]           word,
    input  logic                 is_regs,
    output ead_pkg::ead_region_t region,
    output logic [7:0]           offset
);
    import ead_pkg::*;

    localparam int ARR_PAD = (ARRAY_ADDR_BITS >= 8) ? 1 : 8 - ARRAY_ADDR_BITS;
    localparam int SEC_PAD = 8 - SECURE_OFS_BITS;

    logic [7:0] arr_off;
    logic [7:0] sec_off;

    generate
        if (ARRAY_ADDR_BITS >= 8) begin : g_full_addr
            assign arr_off = word;
        end else begin : g_short_addr
            // R5: upper bits beyond the array size are ignored
            assign arr_off = {{ARR_PAD{1'b0}}, word[ARRAY_ADDR_BITS-1:0]};
        end
    endgenerate

    assign sec_off = {{SEC_PAD{1'b0}}, word[SECURE_OFS_BITS-1:0]};

    always_comb begin
        region = RGN_INVALID;
        offset = 8'd0;
        if (!is_regs) begin
            region = RGN_ARRAY;
            offset = arr_off;
        end else if (word[7:6] == 2'b10) begin
            region = RGN_SECURE;           // R6
            offset = sec_off;
        end else if (word[7:4] == 4'b0110) begin
            region = RGN_LOCK;             // R7
        end else if (word[7:6] == 2'b11) begin
            region = RGN_WPROT;            // R8
        end else begin
            region = RGN_INVALID;          // R9
        end
    end
endmodule

// File: rtl/ead_term_tracker.sv
module ead_term_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic close_evt,
    input  logic open_evt,
    output logic clean_q
);
    // R10: set by stop / host NACK, cleared by an accepted array access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean_q <= 1'b1;
        end else if (close_evt) begin
            clean_q <= 1'b1;
        end else if (open_evt) begin
            clean_q <= 1'b0;
        end
    end
endmodule

// File: rtl/eeprom_addr_decode.sv
module eeprom_addr_decode #(
    parameter int ARRAY_ADDR_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] client_addr,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       host_nack,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       resp_valid,
    output logic       resp_ack,
    output logic       rd_flag,
    output logic       reg_space,
    output logic [2:0] region,
    output logic [7:0] offset
);
    import ead_pkg::*;

    ead_state_t  state_q;
    ead_state_t  state_d;
    logic        accept;
    logic        clean_q;
    logic        dev_is_regs;
    logic        dev_grant;
    ead_region_t word_region;
    logic [7:0]  word_offset;
    logic        array_open;

    assign accept = byte_valid && !start_evt && !stop_evt && !host_nack;

    ead_dev_match u_match (
        .dev_bits    (byte_data[7:1]),
        .client_addr (client_addr),
        .clean_ok    (clean_q),
        .is_regs     (dev_is_regs),
        .grant       (dev_grant)
    );

    ead_word_decode #(
        .ARRAY_ADDR_BITS (ARRAY_ADDR_BITS)
    ) u_word (
        .word    (byte_data),
        .is_regs (reg_space),
        .region  (word_region),
        .offset  (word_offset)
    );

    assign array_open = (state_q == ST_DEV) && accept && dev_grant && !dev_is_regs;

    ead_term_tracker u_term (
        .clk       (clk),
        .rst_n     (rst_n),
        .close_evt (stop_evt || host_nack),
        .open_evt  (array_open),
        .clean_q   (clean_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_DEV;                          // R11
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (host_nack && state_q != ST_IDLE) begin
            state_d = ST_IGNORE;                       // R12
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_DEV: begin
                    if (accept) begin
                        if (!dev_grant)       state_d = ST_IGNORE;
                        else if (byte_data[0]) state_d = ST_DATA;   // R3
                        else                  state_d = ST_WORD;
                    end
                end
                ST_WORD:   if (accept) state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;          // R13
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
            rd_flag    <= 1'b0;
            reg_space  <= 1'b0;
            region     <= RGN_NONE;
            offset     <= 8'd0;
        end else begin
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
            if (start_evt) begin
                rd_flag   <= 1'b0;
                reg_space <= 1'b0;
                region    <= RGN_NONE;
                offset    <= 8'd0;
            end else if (accept) begin
                unique case (state_q)
                    ST_DEV: begin
                        resp_valid <= 1'b1;                 // R4
                        resp_ack   <= dev_grant;
                        if (dev_grant) begin
                            rd_flag   <= byte_data[0];
                            reg_space <= dev_is_regs;
                        end
                    end
                    ST_WORD: begin
                        resp_valid <= 1'b1;
                        resp_ack   <= 1'b1;                 // R9
                        region     <= word_region;
                        offset     <= word_offset;
                    end
                    ST_IDLE, ST_DATA, ST_IGNORE: begin
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ead_chk.sv
module ead_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                start_evt,
    input logic                stop_evt,
    input logic                host_nack,
    input logic                byte_valid,
    input logic [7:1]          dev_bits,
    input logic [2:0]          client_addr,
    input logic                clean_q,
    input ead_pkg::ead_state_t state_q,
    input logic                resp_valid,
    input logic                resp_ack,
    input logic [2:0]          region,
    input logic [7:0]          offset
);
    import ead_pkg::*;

    logic acc;
    assign acc = byte_valid && !start_evt && !stop_evt && !host_nack;

    a_r1_bad_type_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV && acc && dev_bits[7:5] != 3'b101) |=> (resp_valid && !resp_ack));

    a_r2_addr_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV && acc && dev_bits[3:1] != client_addr) |=> (resp_valid && !resp_ack));

    a_r10_open_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV && acc && dev_bits[7:4] == TYPE_REGS && !clean_q) |=> !resp_ack);

    a_r9_word_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WORD && acc) |=> (resp_valid && resp_ack));

    a_r4_resp_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(byte_valid));

    a_r11_start_dev: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state_q == ST_DEV));

    a_r12_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !start_evt) |=> !resp_valid);

    a_r6_secure_range: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_SECURE) |-> (offset[7:5] == 3'b000));

    a_r7_lock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_LOCK || region == RGN_WPROT) |-> (offset == 8'd0));
endmodule

bind eeprom_addr_decode ead_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .host_nack   (host_nack),
    .byte_valid  (byte_valid),
    .dev_bits    (byte_data[7:1]),
    .client_addr (client_addr),
    .clean_q     (clean_q),
    .state_q     (state_q),
    .resp_valid  (resp_valid),
    .resp_ack    (resp_ack),
    .region      (region),
    .offset      (offset)
);

// File: tb/sim_eeprom_addr_decode.sv
`timescale 1ns/1ps
module sim_eeprom_addr_decode;

    localparam logic [2:0] CADDR = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0, stop_evt = 1'b0, host_nack = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'd0;
    logic       rv0, ra0, rd0, rs0, rv1, ra1, rd1, rs1;
    logic [2:0] rg0, rg1;
    logic [7:0] of0, of1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: 0 idle, 1 dev, 2 word, 3 data, 4 ignore
    int         m_state = 0;
    bit         m_clean = 1'b1;
    bit         m_rd = 1'b0, m_space = 1'b0;
    logic [2:0] m_region = 3'd0;
    logic [7:0] m_off8 = 8'd0, m_off7 = 8'd0;

    always #2.5 clk = ~clk;

    eeprom_addr_decode #(.ARRAY_ADDR_BITS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .client_addr(CADDR), .start_evt(start_evt),
        .stop_evt(stop_evt), .host_nack(host_nack), .byte_valid(byte_valid),
        .byte_data(byte_data), .resp_valid(rv0), .resp_ack(ra0), .rd_flag(rd0),
        .reg_space(rs0), .region(rg0), .offset(of0));

    eeprom_addr_decode #(.ARRAY_ADDR_BITS(7)) u1 (
        .clk(clk), .rst_n(rst_n), .client_addr(CADDR), .start_evt(start_evt),
        .stop_evt(stop_evt), .host_nack(host_nack), .byte_valid(byte_valid),
        .byte_data(byte_data), .resp_valid(rv1), .resp_ack(ra1), .rd_flag(rd1),
        .reg_space(rs1), .region(rg1), .offset(of1));

    function automatic logic [2:0] exp_region(bit space, logic [7:0] w);
        if (!space)               return 3'd1;
        if (w[7:6] == 2'b10)      return 3'd2;
        if (w[7:4] == 4'b0110)    return 3'd3;
        if (w[7:6] == 2'b11)      return 3'd4;
        return 3'd5;
    endfunction

    function automatic logic [7:0] exp_offset(bit space, logic [7:0] w, int bits);
        if (!space) return (bits >= 8) ? w : {1'b0, w[6:0]};
        if (w[7:6] == 2'b10) return {3'b000, w[4:0]};
        return 8'd0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_hold(string tag);
        check({tag, " region"}, {29'd0, rg0}, {29'd0, m_region});
        check({tag, " offset"}, {24'd0, of0}, {24'd0, m_off8});
        check({tag, " region7"}, {29'd0, rg1}, {29'd0, m_region});
        check({tag, " offset7"}, {24'd0, of1}, {24'd0, m_off7});
        check({tag, " rd_flag"}, {31'd0, rd0}, {31'd0, m_rd});
        check({tag, " reg_space"}, {31'd0, rs0}, {31'd0, m_space});
    endtask

    task automatic do_start();
        start_evt = 1'b1;
        @(posedge clk); @(negedge clk);
        start_evt = 1'b0;
        m_state = 1; m_rd = 0; m_space = 0; m_region = 0; m_off8 = 0; m_off7 = 0;
    endtask

    task automatic do_stop();
        stop_evt = 1'b1;
        @(posedge clk); @(negedge clk);
        stop_evt = 1'b0;
        m_state = 0; m_clean = 1;
    endtask

    task automatic do_nack();
        host_nack = 1'b1;
        @(posedge clk); @(negedge clk);
        host_nack = 1'b0;
        m_clean = 1;
        if (m_state != 0) m_state = 4;
    endtask

    task automatic send_byte(logic [7:0] b, string tag);
        bit exp_v, exp_a, ok;
        exp_v = 0; exp_a = 0;
        byte_valid = 1'b1; byte_data = b;
        @(posedge clk); @(negedge clk);
        byte_valid = 1'b0;
        case (m_state)
            1: begin
                exp_v = 1;
                ok = (b[7:4] == 4'hA || b[7:4] == 4'hB) && b[3:1] == CADDR &&
                     (b[7:4] != 4'hB || m_clean);
                exp_a = ok;
                if (ok) begin
                    m_rd = b[0]; m_space = (b[7:4] == 4'hB);
                    if (b[7:4] == 4'hA) m_clean = 0;
                    m_state = b[0] ? 3 : 2;
                end else m_state = 4;
            end
            2: begin
                exp_v = 1; exp_a = 1;
                m_region = exp_region(m_space, b);
                m_off8 = exp_offset(m_space, b, 8);
                m_off7 = exp_offset(m_space, b, 7);
                m_state = 3;
            end
            default: ;
        endcase
        check({tag, " resp_valid"}, {31'd0, rv0}, {31'd0, exp_v});
        check({tag, " resp_valid7"}, {31'd0, rv1}, {31'd0, exp_v});
        if (exp_v) check({tag, " resp_ack"}, {31'd0, ra0}, {31'd0, exp_a});
        check_hold(tag);
        @(negedge clk);
        check({tag, " R4 pulse end"}, {31'd0, rv0}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // reset state
        check("R11 reset resp_valid", {31'd0, rv0}, 32'd0);
        check("R11 reset region", {29'd0, rg0}, 32'd0);
        check("R11 reset offset", {24'd0, of0}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        send_byte(8'hAA, "R11 idle byte no response");

        // array write, 8- and 7-bit variants
        do_start();
        send_byte({4'hA, CADDR, 1'b0}, "R1 array dev");
        send_byte(8'h85, "R5 array word");
        send_byte(8'h11, "R13 data byte");
        // repeated start without clean close: register space refused
        do_start();
        send_byte({4'hB, CADDR, 1'b0}, "R10 refused regs");
        send_byte(8'h80, "R12 after refusal");
        do_stop();
        send_byte(8'h80, "R11 after stop");
        // security write-mode acked, bit 5 ignored
        do_start();
        send_byte({4'hB, CADDR, 1'b0}, "R6 regs write dev");
        send_byte(8'hA7, "R6 secure word");
        do_start();
        send_byte({4'hB, CADDR, 1'b0}, "R7 regs dev");
        send_byte(8'h6F, "R7 lock word");
        send_byte(8'h55, "R13 data after lock");
        do_start();
        send_byte({4'hB, CADDR, 1'b0}, "R8 regs dev");
        send_byte(8'hC3, "R8 wprot word");
        do_start();
        send_byte({4'hB, CADDR, 1'b0}, "R9 regs dev");
        send_byte(8'h15, "R9 invalid word");
        // array read, then host NACK reopens register access
        do_start();
        send_byte({4'hA, CADDR, 1'b1}, "R3 array read");
        do_nack();
        send_byte(8'h00, "R12 after host nack");
        do_start();
        send_byte({4'hB, CADDR, 1'b1}, "R10 regs after nack");
        do_start();
        send_byte({4'h5, CADDR, 1'b0}, "R1 bad type");
        do_start();
        send_byte({4'hA, ~CADDR, 1'b0}, "R2 addr mismatch");

        // constrained random transactions
        for (int t = 0; t < 600; t++) begin
            logic [3:0] ty;
            logic [2:0] ad;
            int sel;
            sel = $urandom % 4;
            ty = (sel == 0) ? 4'hA : (sel == 1 || sel == 2) ? 4'hB : 4'($urandom);
            ad = ($urandom % 4 == 0) ? 3'($urandom) : CADDR;
            do_start();
            send_byte({ty, ad, 1'($urandom)}, "R10 random dev");
            if (m_state == 2) begin
                logic [7:0] w;
                sel = $urandom % 5;
                case (sel)
                    0: w = {2'b10, 6'($urandom)};
                    1: w = {4'b0110, 4'($urandom)};
                    2: w = {2'b11, 6'($urandom)};
                    3: w = {2'b00, 6'($urandom)};
                    default: w = 8'($urandom);
                endcase
                send_byte(w, "R9 random word");
            end
            if ($urandom % 3 == 0) send_byte(8'($urandom), "R13 random data");
            sel = $urandom % 3;
            if (sel == 0) do_stop();
            else if (sel == 1) do_nack();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule